// File: doc/BRIEF.md
# Label and SDI Match Filter

This block decides what happens to one received ARINC 429 word. A word arrives with the number of the receive channel that delivered it. The block then walks a host-loaded table of 128 sixteen-bit entries, one entry per clock, starting at entry 0. It stops at the first entry whose label, source/destination (S/D) and channel criteria all accept the word. That entry's index becomes the receive RAM address. Two further fields in the entry say whether the word also goes into the channel's receive FIFO and which general-purpose interrupt, if any, to raise.

If no entry accepts the word, the word is dropped and a one-cycle no-match pulse is produced. While a search runs the block shows `busy`, and it takes no new word. The host writes table entries through a simple write port. A four-bit input enables all-call acceptance separately for each channel.

Entry layout (bit 15 down to 0):
- bits 15:14: interrupt select.
- bits 13:12: channel.
- bit 11: FIFO copy.
- bit 10: S/D don't-care.
- bits 9:8: S/D value.
- bits 7:0: label.

In the received word, the label is bits 7:0 and S/D is bits 9:8.

Top module: `lsm_filter`

## Requirements
- R1: After reset, `busy`, `store_valid`, `no_match`, `fifo_push` and `irq_sel` are all 0.
- R2: An entry label field (bits 7:0) that is nonzero accepts only a word whose bits 7:0 equal it. A label field of 0 accepts any label.
- R3: The entry S/D test passes when entry bits 9:8 equal word bits 9:8, or when entry bit 10 is 1.
- R4: When `allcall_en[ch]` is 1 for the receiving channel `ch`, a word with S/D bits 00 passes the S/D test of every entry on that channel. When that enable bit is 0, S/D 00 gets no special treatment.
- R5: An entry accepts a word only if entry bits 13:12 equal `word_chan`.
- R6: With several accepting entries, the lowest index wins. In the result cycle, `store_addr` equals that index and `store_data` equals the accepted word.
- R7: In the result cycle, `fifo_push` equals bit 11 of the winning entry. Outside a store result it is 0.
- R8: In the result cycle, `irq_sel` equals bits 15:14 of the winning entry, where 00 means no interrupt. Outside a store result it is 0.
- R9: A word is accepted on a clock edge where `word_valid` is 1 and `busy` is 0. When entry k wins, `store_valid` is high for exactly one cycle, starting k+1 clock edges after the accepting edge. `busy` is high from the accepting edge until that same result edge.
- R10: When no entry accepts the word, `no_match` pulses for one cycle, 128 edges after the accepting edge, and `store_valid` stays 0.
- R11: Words offered while `busy` is 1 are ignored. The search in progress and its reported word are not altered.
- R12: With `tbl_we` at 1, entry `tbl_addr` takes `tbl_wdata` at the clock edge, and later searches use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | 7 | Table entry index to write |
| tbl_wdata | input | 16 | Table entry value |
| allcall_en | input | 4 | Per-channel all-call enable |
| word_valid | input | 1 | Received word offered |
| word_data | input | 32 | Received ARINC 429 word |
| word_chan | input | 2 | Receiving channel number |
| busy | output | 1 | Search in progress, new words ignored |
| store_valid | output | 1 | One-cycle store request |
| store_addr | output | 7 | Receive RAM address (winning entry index) |
| store_data | output | 32 | Word to store |
| fifo_push | output | 1 | Also push word into channel FIFO |
| irq_sel | output | 2 | Interrupt select, 0 for none |
| no_match | output | 1 | One-cycle pulse: word discarded |

## Verification
The assertions assume that the table and `allcall_en` stay constant while `busy` is high. The result pulse and the no-match window are only meaningful under that condition. The stimulus therefore writes entries and changes all-call enables only between searches. While a search runs, the only activity is offering extra words, which tests that they are ignored. The stimulus also fills every entry the test does not use with a value that no test word can hit, so the no-match case can be reached.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef struct packed {
    logic [1:0] irq;
    logic [1:0] chan;
    logic       fifo;
    logic       sd_any;
    logic [1:0] sd;
    logic [7:0] label;
  } lsm_entry_t;

  localparam int ENTRY_W = $bits(lsm_entry_t);
  localparam int WORD_W  = 32;
  localparam int CHAN_W  = 2;
  localparam int NCHAN   = 1 << CHAN_W;

  typedef enum logic {S_IDLE = 1'b0, S_SEARCH = 1'b1} lsm_state_t;
endpackage

// File: rtl/lsm_table.sv
module lsm_table
  import lsm_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  lsm_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output lsm_entry_t       rd_entry
);
  lsm_entry_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic row_en;
    assign row_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '0;
      else if (row_en) mem_q[g] <= wr_entry;
    end
  end

  assign rd_entry = mem_q[rd_idx];
endmodule

// File: rtl/lsm_compare.sv
module lsm_compare
  import lsm_pkg::*;
(
  input  lsm_entry_t        entry,
  input  logic [WORD_W-1:0] word,
  input  logic [CHAN_W-1:0] chan,
  input  logic [NCHAN-1:0]  allcall_en,
  output logic              hit
);
  logic label_ok, sd_ok, chan_ok, allcall_ok;

  always_comb begin
    label_ok   = (entry.label == 8'h00) || (entry.label == word[7:0]);
    allcall_ok = allcall_en[chan] && (word[9:8] == 2'b00);
    sd_ok      = entry.sd_any || (entry.sd == word[9:8]) || allcall_ok;
    chan_ok    = (entry.chan == chan);
    hit        = label_ok && sd_ok && chan_ok;
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [CHAN_W-1:0] word_chan,
  input  logic              hit,
  input  lsm_entry_t        entry,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] cur_word,
  output logic [CHAN_W-1:0] cur_chan,
  output logic              busy,
  output logic              store_valid,
  output logic [IDX_W-1:0]  store_addr,
  output logic              fifo_push,
  output logic [1:0]        irq_sel,
  output logic              no_match
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  lsm_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q;
  logic [CHAN_W-1:0] chan_q;
  logic              load_word;
  logic              sv_q, sv_d, nm_q, nm_d, fp_q, fp_d;
  logic [1:0]        irq_q, irq_d;
  logic [IDX_W-1:0]  addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    load_word = 1'b0;
    sv_d      = 1'b0;
    nm_d      = 1'b0;
    fp_d      = 1'b0;
    irq_d     = 2'b00;
    addr_d    = addr_q;
    addr_en   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (word_valid) begin
          state_d   = S_SEARCH;
          idx_d     = '0;
          load_word = 1'b1;
        end
      end
      S_SEARCH: begin
        if (hit) begin
          state_d = S_IDLE;
          sv_d    = 1'b1;
          fp_d    = entry.fifo;
          irq_d   = entry.irq;
          addr_d  = idx_q;
          addr_en = 1'b1;
        end else if (idx_q == LAST) begin
          state_d = S_IDLE;
          nm_d    = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      sv_q    <= 1'b0;
      nm_q    <= 1'b0;
      fp_q    <= 1'b0;
      irq_q   <= 2'b00;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sv_q    <= sv_d;
      nm_q    <= nm_d;
      fp_q    <= fp_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      chan_q <= '0;
    end else if (load_word) begin
      word_q <= word_data;
      chan_q <= word_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign idx         = idx_q;
  assign cur_word    = word_q;
  assign cur_chan    = chan_q;
  assign busy        = (state_q == S_SEARCH);
  assign store_valid = sv_q;
  assign store_addr  = addr_q;
  assign fifo_push   = fp_q;
  assign irq_sel     = irq_q;
  assign no_match    = nm_q;
endmodule

// File: rtl/lsm_filter.sv
module lsm_filter
  import lsm_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [15:0]       tbl_wdata,
  input  logic [NCHAN-1:0]  allcall_en,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [CHAN_W-1:0] word_chan,
  output logic              busy,
  output logic              store_valid,
  output logic [IDX_W-1:0]  store_addr,
  output logic [WORD_W-1:0] store_data,
  output logic              fifo_push,
  output logic [1:0]        irq_sel,
  output logic              no_match
);
  logic [IDX_W-1:0]  scan_idx;
  lsm_entry_t        scan_entry;
  logic [WORD_W-1:0] cur_word;
  logic [CHAN_W-1:0] cur_chan;
  logic              scan_hit;

  lsm_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_addr),
    .wr_entry (lsm_entry_t'(tbl_wdata)),
    .rd_idx   (scan_idx),
    .rd_entry (scan_entry)
  );

  lsm_compare u_cmp (
    .entry      (scan_entry),
    .word       (cur_word),
    .chan       (cur_chan),
    .allcall_en (allcall_en),
    .hit        (scan_hit)
  );

  lsm_seq #(.DEPTH(DEPTH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_chan   (word_chan),
    .hit         (scan_hit),
    .entry       (scan_entry),
    .idx         (scan_idx),
    .cur_word    (cur_word),
    .cur_chan    (cur_chan),
    .busy        (busy),
    .store_valid (store_valid),
    .store_addr  (store_addr),
    .fifo_push   (fifo_push),
    .irq_sel     (irq_sel),
    .no_match    (no_match)
  );

  assign store_data = cur_word;
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_valid,
  input logic             busy,
  input logic             store_valid,
  input logic [31:0]      store_data,
  input logic             fifo_push,
  input logic [1:0]       irq_sel,
  input logic             no_match
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_valid && no_match));

  p_fifo_with_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> store_valid);

  p_irq_with_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel != 2'b00) |-> store_valid);

  p_accept_sets_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !busy) |=> busy);

  p_busy_ends_with_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (store_valid || no_match));

  p_result_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid || no_match) |-> (!busy && $past(busy)));

  p_nomatch_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (busy_cnt == CNT_W'(DEPTH)));

  p_word_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(store_data));
endmodule

bind lsm_filter lsm_checker #(.DEPTH(DEPTH)) u_lsm_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_valid  (word_valid),
  .busy        (busy),
  .store_valid (store_valid),
  .store_data  (store_data),
  .fifo_push   (fifo_push),
  .irq_sel     (irq_sel),
  .no_match    (no_match)
);

// File: tb/tb_lsm_filter.sv
`timescale 1ns/1ps
module tb_lsm_filter;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [6:0]  tbl_addr;
  logic [15:0] tbl_wdata;
  logic [3:0]  allcall_en;
  logic        word_valid;
  logic [31:0] word_data;
  logic [1:0]  word_chan;
  logic        busy, store_valid, fifo_push, no_match;
  logic [6:0]  store_addr;
  logic [31:0] store_data;
  logic [1:0]  irq_sel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lsm_filter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .allcall_en(allcall_en), .word_valid(word_valid),
    .word_data(word_data), .word_chan(word_chan), .busy(busy),
    .store_valid(store_valid), .store_addr(store_addr), .store_data(store_data),
    .fifo_push(fifo_push), .irq_sel(irq_sel), .no_match(no_match)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ent(input logic [7:0] lab, input logic [1:0] sd,
      input bit dc, input bit ff, input logic [1:0] ch, input logic [1:0] irq);
    return {irq, ch, ff, dc, sd, lab};
  endfunction

  // Reference model: behavioural table and countdown
  logic [15:0] ref_tbl [DEPTH];
  bit          m_busy;
  int          m_wait, m_hit;
  logic [31:0] m_word;
  bit          exp_sv, exp_nm, exp_fp;
  logic [1:0]  exp_irq;
  logic [6:0]  exp_addr;

  function automatic int ref_search(input logic [31:0] w, input logic [1:0] ch);
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] e;
      bit lab_ok, sd_ok;
      e      = ref_tbl[i];
      lab_ok = (e[7:0] == 8'h00) || (e[7:0] == w[7:0]);
      sd_ok  = e[10] || (e[9:8] == w[9:8]) || (allcall_en[ch] && w[9:8] == 2'b00);
      if (lab_ok && sd_ok && e[13:12] == ch) return i;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ref_tbl[i] <= '0;
      m_busy <= 0; m_wait <= 0; m_hit <= -1; m_word <= '0;
      exp_sv <= 0; exp_nm <= 0; exp_fp <= 0; exp_irq <= 0; exp_addr <= 0;
    end else begin
      exp_sv <= 0; exp_nm <= 0; exp_fp <= 0; exp_irq <= 0;
      if (tbl_we) ref_tbl[tbl_addr] <= tbl_wdata;
      if (m_busy) begin
        if (m_wait == 1) begin
          m_busy <= 0;
          if (m_hit >= 0) begin
            exp_sv   <= 1;
            exp_addr <= 7'(m_hit);
            exp_fp   <= ref_tbl[m_hit][11];
            exp_irq  <= ref_tbl[m_hit][15:14];
          end else begin
            exp_nm <= 1;
          end
        end else begin
          m_wait <= m_wait - 1;
        end
      end else if (word_valid) begin
        int h;
        h = ref_search(word_data, word_chan);
        m_busy <= 1;
        m_hit  <= h;
        m_word <= word_data;
        m_wait <= (h >= 0) ? h + 1 : DEPTH;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      chk(busy == m_busy, "R9 busy", {31'd0, busy}, {31'd0, m_busy});
      chk(store_valid == exp_sv, "R6 store_valid", {31'd0, store_valid}, {31'd0, exp_sv});
      chk(no_match == exp_nm, "R10 no_match", {31'd0, no_match}, {31'd0, exp_nm});
      chk(fifo_push == exp_fp, "R7 fifo_push", {31'd0, fifo_push}, {31'd0, exp_fp});
      chk(irq_sel == exp_irq, "R8 irq_sel", {30'd0, irq_sel}, {30'd0, exp_irq});
      if (exp_sv) begin
        chk(store_addr == exp_addr, "R6 store_addr", {25'd0, store_addr}, {25'd0, exp_addr});
        chk(store_data == m_word, "R6 store_data", store_data, m_word);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    finish_run();
  end

  task automatic wr(input int idx, input logic [15:0] v);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 7'(idx); tbl_wdata = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // Offer a word and wait for its result; exp_idx < 0 means no match expected
  task automatic run_word(input logic [31:0] w, input logic [1:0] ch, input int exp_idx,
                          input bit efp, input logic [1:0] eirq, input string tag);
    int n;
    @(negedge clk);
    word_valid = 1; word_data = w; word_chan = ch;
    @(negedge clk);
    word_valid = 0;
    n = 0;
    while (!(store_valid || no_match) && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (exp_idx < 0) begin
      chk(no_match && !store_valid, tag, {31'd0, no_match}, 32'd1);
    end else begin
      chk(store_valid && store_addr == 7'(exp_idx), tag, {25'd0, store_addr}, exp_idx);
      chk(fifo_push == efp, tag, {31'd0, fifo_push}, {31'd0, efp});
      chk(irq_sel == eirq, tag, {30'd0, irq_sel}, {30'd0, eirq});
      chk(store_data == w, tag, store_data, w);
    end
  endtask

  initial begin
    rst_n = 0; tbl_we = 0; tbl_addr = 0; tbl_wdata = 0; allcall_en = 0;
    word_valid = 0; word_data = 0; word_chan = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: outputs idle after reset
    chk(!busy && !store_valid && !no_match && !fifo_push && irq_sel == 0, "R1 reset",
        {26'd0, busy, store_valid, no_match, fifo_push, irq_sel}, 32'd0);

    // Filler no test word can hit: label FF, S/D 3, channel 3
    for (int i = 0; i < DEPTH; i++) wr(i, ent(8'hFF, 2'd3, 0, 0, 2'd3, 2'd0));
    wr(5,   ent(8'h21, 2'd1, 0, 0, 2'd0, 2'd1));
    wr(10,  ent(8'h00, 2'd2, 0, 1, 2'd1, 2'd2));
    wr(20,  ent(8'h40, 2'd0, 1, 0, 2'd2, 2'd3));
    wr(30,  ent(8'h55, 2'd0, 0, 1, 2'd3, 2'd1));
    wr(31,  ent(8'h55, 2'd0, 0, 0, 2'd3, 2'd2));
    wr(31,  ent(8'h55, 2'd0, 0, 0, 2'd0, 2'd2));
    wr(40,  ent(8'h12, 2'd1, 0, 0, 2'd1, 2'd0));
    wr(127, ent(8'h66, 2'd2, 0, 1, 2'd3, 2'd3));

    run_word(32'h1234_0121, 2'd0, 5,  0, 2'd1, "R2 exact label");
    run_word(32'h0000_0222, 2'd0, -1, 0, 2'd0, "R2 label mismatch");
    run_word(32'hABCD_0277, 2'd1, 10, 1, 2'd2, "R2 zero label wildcard");
    run_word(32'h0000_0340, 2'd2, 20, 0, 2'd3, "R3 S/D don't-care");
    run_word(32'h0000_0221, 2'd0, -1, 0, 2'd0, "R3 S/D mismatch");
    run_word(32'h0000_0121, 2'd2, -1, 0, 2'd0, "R5 wrong channel");
    run_word(32'h0000_0021, 2'd0, -1, 0, 2'd0, "R4 all-call off");
    @(negedge clk); allcall_en = 4'b0001;
    run_word(32'h0000_0021, 2'd0, 5,  0, 2'd1, "R4 all-call on");
    run_word(32'h0000_0012, 2'd1, -1, 0, 2'd0, "R4 all-call other channel");
    @(negedge clk); allcall_en = 4'b0000;
    run_word(32'h0000_0055, 2'd3, 30, 1, 2'd1, "R6 first match wins");
    run_word(32'h0000_0266, 2'd3, 127, 1, 2'd3, "R9 last entry");
    run_word(32'h0000_0011, 2'd3, -1, 0, 2'd0, "R10 no entry");

    // R11: words offered during a search are ignored
    @(negedge clk);
    word_valid = 1; word_data = 32'h0000_0112; word_chan = 2'd1;
    @(negedge clk);
    word_data = 32'h0000_0121; word_chan = 2'd0;
    repeat (3) @(negedge clk);
    word_valid = 0;
    while (!(store_valid || no_match)) @(negedge clk);
    chk(store_valid && store_addr == 7'd40, "R11 busy ignore addr", {25'd0, store_addr}, 32'd40);
    chk(store_data == 32'h0000_0112, "R11 busy ignore data", store_data, 32'h0000_0112);
    @(negedge clk);
    chk(!busy, "R11 no late accept", {31'd0, busy}, 32'd0);

    // R12: rewrite an entry, later search uses it
    wr(30, ent(8'h55, 2'd0, 0, 0, 2'd0, 2'd0));
    run_word(32'h0000_0055, 2'd3, -1, 0, 2'd0, "R12 rewritten entry");
    run_word(32'h0000_0055, 2'd0, 30, 0, 2'd0, "R12 new entry hits");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule